// File: doc/BRIEF.md
# Privileged Processor Status Word

This block holds the 16-bit status word of a processor core. The word has two bytes. The upper byte carries the system state, including the supervisor bit at position 13. The lower byte carries the condition flags that arithmetic results leave behind.

The ALU feeds per-flag update strobes and values. The instruction sequencer issues byte-selective writes and reads. A read asks for either the whole word or the flag byte alone.

The unit enforces privilege by byte. The privilege level in force is the stored supervisor bit, which is also driven out as the supervisor-mode indicator. A user-mode write that touches the system byte is refused and reported on a violation output. A configuration input (or a build-time policy) decides whether user code may read the whole word. The unit only flags offences; trapping and vectoring are left to the surrounding core.

Top module: `stat_word_unit`

## Requirements
- R1: After reset the word reads 0x2000: the supervisor bit (bit 13) is set and every flag is clear.
- R2: A supervisor write with byte enable bit 1 set loads the upper byte with the write data ANDed with the implemented-bit mask. The default mask is 0xA7, so bits 15, 13, 10, 9 and 8 are kept and the other upper bits read zero.
- R3: A write with byte enable bit 1 set while the supervisor bit is clear raises the violation output in that same cycle. The whole write is discarded, so neither byte changes from the write.
- R4: A write with byte enable bit 0 set loads the flag byte in either mode. Data bits 0 to 4 are stored, and bits 5 to 7 of the word always read zero.
- R5: Each ALU strobe bit k loads flag k from ALU value bit k. Flags whose strobe is low keep their value. The bit positions are carry 0, overflow 1, zero 2, negative 3 and extend 4, so carry can change while extend holds.
- R6: When an accepted flag-byte write and ALU strobes fall in the same cycle, all five flags take the write data. When the write is refused, the ALU updates still apply.
- R7: A whole-word read (read enable with the full-read select high) in user mode with the privileged-read configuration high raises the violation output and returns zero. With the configuration low it returns the word without a violation. In supervisor mode it always returns the word.
- R8: A flag-byte read (full-read select low) never raises a violation and returns the flag byte in bits 7:0 with zeros above. With no read enable, the read data is zero.
- R9: The supervisor output equals bit 13 of the word. Each flag output equals its bit of the word. Clearing bit 13 by a supervisor write enters user mode from the next cycle on.
- R10: The violation output is high only in a cycle that carries an offending request. A write whose byte enables are both zero is a no-op without violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_upd_i | input | 5 | Per-flag update strobes (C,V,Z,N,X at bits 0..4) |
| alu_val_i | input | 5 | New flag values, same bit order |
| wr_en_i | input | 1 | Write request |
| wr_be_i | input | 2 | Byte enables: bit 1 system byte, bit 0 flag byte |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read request |
| rd_full_i | input | 1 | 1 = whole word, 0 = flag byte only |
| rd_priv_cfg_i | input | 1 | 1 = whole-word read is privileged |
| status_o | output | 16 | Current status word |
| rd_data_o | output | 16 | Read result (combinational) |
| flag_c_o | output | 1 | Carry flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_z_o | output | 1 | Zero flag |
| flag_n_o | output | 1 | Negative flag |
| flag_x_o | output | 1 | Extend flag |
| super_o | output | 1 | Supervisor mode |
| viol_o | output | 1 | Privilege violation, same cycle as request |

## Verification
Two of the block's functions can land on the flags in one clock: an ALU flag update and a sequencer write of the flag byte. The bench provokes this in directed cycles, both with the write accepted and with it refused for touching the system byte in user mode. It also drives all strobes alongside random writes in the random phase. A bench reference model judges each such cycle: the write wins when it is accepted, and the ALU values land when the write is refused.

// File: rtl/stat_word_pkg.sv
package stat_word_pkg;
   localparam int unsigned NFLAGS = 5;
   // flag order inside the condition byte
   typedef enum logic [2:0] {
      FL_C = 3'd0,
      FL_V = 3'd1,
      FL_Z = 3'd2,
      FL_N = 3'd3,
      FL_X = 3'd4
   } flag_idx_e;
   // read protection policy selected at build time
   localparam int unsigned RDP_BY_INPUT = 0;
   localparam int unsigned RDP_ALWAYS   = 1;
   localparam int unsigned RDP_NEVER    = 2;
endpackage

// File: rtl/sw_gate.sv
module sw_gate #(
   parameter int unsigned RD_POLICY = 0
) (
   input  logic       super_i,
   input  logic       wr_en_i,
   input  logic [1:0] wr_be_i,
   input  logic       rd_en_i,
   input  logic       rd_full_i,
   input  logic       rd_priv_cfg_i,
   output logic       wr_sys_ok_o,
   output logic       wr_cc_ok_o,
   output logic       rd_deny_o,
   output logic       viol_o
);
   logic wr_deny;
   logic full_rd_priv;

   generate
      if (RD_POLICY == stat_word_pkg::RDP_ALWAYS) begin : g_rd_always
         logic unused_cfg;
         assign unused_cfg   = rd_priv_cfg_i;
         assign full_rd_priv = 1'b1;
      end else if (RD_POLICY == stat_word_pkg::RDP_NEVER) begin : g_rd_never
         logic unused_cfg;
         assign unused_cfg   = rd_priv_cfg_i;
         assign full_rd_priv = 1'b0;
      end else begin : g_rd_input
         assign full_rd_priv = rd_priv_cfg_i;
      end
   endgenerate

   // a refused write is refused as a whole
   assign wr_deny     = wr_en_i & wr_be_i[1] & ~super_i;
   assign wr_sys_ok_o = wr_en_i & wr_be_i[1] & super_i;
   assign wr_cc_ok_o  = wr_en_i & wr_be_i[0] & ~wr_deny;
   assign rd_deny_o   = rd_en_i & rd_full_i & full_rd_priv & ~super_i;
   assign viol_o      = wr_deny | rd_deny_o;
endmodule

// File: rtl/sw_ccr_reg.sv
module sw_ccr_reg #(
   parameter int unsigned NF = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] upd_i,
   input  logic [NF-1:0] val_i,
   input  logic          load_i,
   input  logic [NF-1:0] load_d_i,
   output logic [NF-1:0] q_o
);
   generate
      for (genvar k = 0; k < NF; k++) begin : g_flag
         logic nxt;
         always_comb begin
            nxt = q_o[k];
            if (upd_i[k]) nxt = val_i[k];
            if (load_i)   nxt = load_d_i[k];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o[k] <= 1'b0;
            else        q_o[k] <= nxt;
         end
      end
   endgenerate
endmodule

// File: rtl/sw_sys_reg.sv
module sw_sys_reg #(
   parameter int unsigned       BW    = 8,
   parameter logic [BW-1:0]     IMPL  = 8'hA7,
   parameter logic [BW-1:0]     RST_V = 8'h20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [BW-1:0] d_i,
   output logic [BW-1:0] q_o
);
   generate
      for (genvar i = 0; i < BW; i++) begin : g_bit
         if (IMPL[i]) begin : g_impl
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      q_o[i] <= RST_V[i];
               else if (load_i) q_o[i] <= d_i[i];
            end
         end else begin : g_tied
            logic unused_bit;
            assign unused_bit = d_i[i] ^ load_i ^ clk ^ rst_n;
            assign q_o[i]     = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/stat_word_unit.sv
module stat_word_unit #(
   parameter int unsigned   BYTE_W    = 8,
   parameter int unsigned   SUP_BIT   = 13,
   parameter logic [7:0]    SYS_IMPL  = 8'hA7,
   parameter int unsigned   RD_POLICY = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [4:0]  alu_upd_i,
   input  logic [4:0]  alu_val_i,
   input  logic        wr_en_i,
   input  logic [1:0]  wr_be_i,
   input  logic [15:0] wr_data_i,
   input  logic        rd_en_i,
   input  logic        rd_full_i,
   input  logic        rd_priv_cfg_i,
   output logic [15:0] status_o,
   output logic [15:0] rd_data_o,
   output logic        flag_c_o,
   output logic        flag_v_o,
   output logic        flag_z_o,
   output logic        flag_n_o,
   output logic        flag_x_o,
   output logic        super_o,
   output logic        viol_o
);
   import stat_word_pkg::*;

   localparam int unsigned WORD_W  = 2 * BYTE_W;
   localparam int unsigned SUP_LOC = SUP_BIT - BYTE_W;
   localparam logic [BYTE_W-1:0] SYS_RST = BYTE_W'(1) << SUP_LOC;

   initial begin
      assert (BYTE_W == 8) else $error("status word needs 8-bit bytes");
      assert (SUP_BIT >= BYTE_W && SUP_BIT < WORD_W) else $error("supervisor bit outside system byte");
      assert (SYS_IMPL[SUP_LOC] == 1'b1) else $error("supervisor bit must be implemented");
      assert (RD_POLICY <= RDP_NEVER) else $error("unknown read policy");
   end

   logic              wr_sys_ok, wr_cc_ok, rd_deny;
   logic [BYTE_W-1:0] sys_q;
   logic [NFLAGS-1:0] cc_q;
   logic [BYTE_W-1:0] cc_byte;
   logic              unused_wd;

   assign unused_wd = ^wr_data_i[BYTE_W-1:NFLAGS];

   sw_gate #(.RD_POLICY(RD_POLICY)) u_gate (
      .super_i       (sys_q[SUP_LOC]),
      .wr_en_i       (wr_en_i),
      .wr_be_i       (wr_be_i),
      .rd_en_i       (rd_en_i),
      .rd_full_i     (rd_full_i),
      .rd_priv_cfg_i (rd_priv_cfg_i),
      .wr_sys_ok_o   (wr_sys_ok),
      .wr_cc_ok_o    (wr_cc_ok),
      .rd_deny_o     (rd_deny),
      .viol_o        (viol_o)
   );

   sw_sys_reg #(.BW(BYTE_W), .IMPL(SYS_IMPL), .RST_V(SYS_RST)) u_sys (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (wr_sys_ok),
      .d_i    (wr_data_i[WORD_W-1:BYTE_W]),
      .q_o    (sys_q)
   );

   sw_ccr_reg #(.NF(NFLAGS)) u_ccr (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd_i    (alu_upd_i),
      .val_i    (alu_val_i),
      .load_i   (wr_cc_ok),
      .load_d_i (wr_data_i[NFLAGS-1:0]),
      .q_o      (cc_q)
   );

   assign cc_byte  = {{(BYTE_W-NFLAGS){1'b0}}, cc_q};
   assign status_o = {sys_q, cc_byte};

   always_comb begin
      rd_data_o = '0;
      if (rd_en_i) begin
         if (!rd_full_i)   rd_data_o = {{BYTE_W{1'b0}}, cc_byte};
         else if (!rd_deny) rd_data_o = status_o;
      end
   end

   assign flag_c_o = cc_q[FL_C];
   assign flag_v_o = cc_q[FL_V];
   assign flag_z_o = cc_q[FL_Z];
   assign flag_n_o = cc_q[FL_N];
   assign flag_x_o = cc_q[FL_X];
   assign super_o  = sys_q[SUP_LOC];
endmodule

// File: rtl/sw_checker.sv
module sw_checker #(
   parameter int unsigned SUP_BIT   = 13,
   parameter int unsigned RD_POLICY = 0
) (
   input logic        clk,
   input logic        rst_n,
   input logic [4:0]  alu_upd_i,
   input logic        wr_en_i,
   input logic [1:0]  wr_be_i,
   input logic [15:0] wr_data_i,
   input logic        rd_en_i,
   input logic        rd_full_i,
   input logic        rd_priv_cfg_i,
   input logic [15:0] status_o,
   input logic [15:0] rd_data_o,
   input logic        flag_x_o,
   input logic        super_o,
   input logic        viol_o
);
   a_r3_sys_refused: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_be_i[1] && !status_o[SUP_BIT]) |-> viol_o);

   a_r3_sys_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_be_i[1] && !super_o) |=> $stable(status_o[15:8]));

   a_r10_cause: assert property (@(posedge clk) disable iff (!rst_n)
      viol_o |-> (wr_en_i || rd_en_i));

   a_r5_x_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_upd_i[4] && !(wr_en_i && wr_be_i[0])) |=> $stable(flag_x_o));

   a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_be_i[0] && !viol_o) |=> (status_o[4:0] == $past(wr_data_i[4:0])));

   a_r7_full_read_block: assert property (@(posedge clk) disable iff (!rst_n)
      (RD_POLICY == 0 && rd_en_i && rd_full_i && rd_priv_cfg_i && !super_o)
      |-> (viol_o && rd_data_o == 16'h0000));

   a_r8_cc_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !rd_full_i) |-> (rd_data_o == {8'h00, status_o[7:0]}));

   always_comb begin
      if (rst_n) a_r4_pad_zero: assert (status_o[7:5] == 3'b000);
   end
endmodule

bind stat_word_unit sw_checker #(.SUP_BIT(SUP_BIT), .RD_POLICY(RD_POLICY)) u_chk (.*);

// File: tb/test_stat_word_unit.sv
module test_stat_word_unit;
   // 10 units per period: 100 MHz at 1 ns units
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  alu_upd_i = '0, alu_val_i = '0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_be_i = '0;
   logic [15:0] wr_data_i = '0;
   logic        rd_en_i = 1'b0, rd_full_i = 1'b0, rd_priv_cfg_i = 1'b0;
   logic [15:0] status_o, rd_data_o;
   logic        flag_c_o, flag_v_o, flag_z_o, flag_n_o, flag_x_o, super_o, viol_o;

   int checks = 0;
   int errors = 0;
   logic [15:0] model = 16'h2000;
   string prev_tag = "R1";
   bit done = 1'b0;

   always #5 clk = ~clk;

   stat_word_unit i_stat_word_unit (.*);

   function automatic logic [15:0] f_next(input logic [15:0] s, input logic [4:0] upd,
         input logic [4:0] val, input logic we, input logic [1:0] be, input logic [15:0] d);
      logic [15:0] n = s;
      logic bad = we && be[1] && !s[13];
      for (int k = 0; k < 5; k++) if (upd[k]) n[k] = val[k];
      if (we && !bad) begin
         if (be[1]) n[15:8] = d[15:8] & 8'hA7;
         if (be[0]) n[7:0]  = {3'b000, d[4:0]};
      end
      return n;
   endfunction

   function automatic logic f_viol(input logic [15:0] s, input logic we, input logic [1:0] be,
         input logic re, input logic rf, input logic cfg);
      return (we && be[1] && !s[13]) || (re && rf && cfg && !s[13]);
   endfunction

   function automatic logic [15:0] f_rd(input logic [15:0] s, input logic re, input logic rf,
         input logic cfg);
      if (!re) return 16'h0;
      if (!rf) return {8'h00, s[7:0]};
      if (cfg && !s[13]) return 16'h0;
      return s;
   endfunction

   task automatic chk(input string tag, input string what, input logic [15:0] act,
         input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic cyc(input logic [4:0] upd, input logic [4:0] val, input logic we,
         input logic [1:0] be, input logic [15:0] d, input logic re, input logic rf,
         input logic cfg, input string tag);
      @(negedge clk);
      chk(prev_tag, "status", status_o, model);
      chk("R9", "flags", {super_o, flag_x_o, flag_n_o, flag_z_o, flag_v_o, flag_c_o},
          {model[13], model[4], model[3], model[2], model[1], model[0]});
      alu_upd_i = upd; alu_val_i = val; wr_en_i = we; wr_be_i = be; wr_data_i = d;
      rd_en_i = re; rd_full_i = rf; rd_priv_cfg_i = cfg;
      #1;
      chk((tag == "R7" || tag == "R8") ? tag : "R10", "viol", {15'h0, viol_o},
          {15'h0, f_viol(model, we, be, re, rf, cfg)});
      chk((tag == "R7") ? "R7" : "R8", "rd_data", rd_data_o, f_rd(model, re, rf, cfg));
      model = f_next(model, upd, val, we, be, d);
      prev_tag = tag;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      alu_upd_i = '0; wr_en_i = 1'b0; wr_be_i = '0; rd_en_i = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      model = 16'h2000;
      prev_tag = "R1";
   endtask

   initial begin
      void'($urandom(32'd4242));
      do_reset();
      // R1 reset value seen at next status check
      cyc(5'h00, 5'h00, 1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 1'b0, "R1");
      // R2 supervisor full write, mask applied; R4 pad bits zero
      cyc(5'h00, 5'h00, 1'b1, 2'b11, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R2");
      // R4 load extend only
      cyc(5'h00, 5'h00, 1'b1, 2'b01, 16'h0010, 1'b1, 1'b1, 1'b1, "R4");
      // R5 carry update leaves extend
      cyc(5'h01, 5'h01, 1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 1'b0, "R5");
      cyc(5'h01, 5'h00, 1'b0, 2'b00, 16'h0000, 1'b1, 1'b0, 1'b0, "R5");
      // R6 write beats ALU
      cyc(5'h1F, 5'h1F, 1'b1, 2'b01, 16'h0005, 1'b0, 1'b0, 1'b0, "R6");
      // R10 write with no enables is a no-op
      cyc(5'h00, 5'h00, 1'b1, 2'b00, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R10");
      // R9 drop to user mode
      cyc(5'h00, 5'h00, 1'b1, 2'b10, 16'h0700, 1'b0, 1'b0, 1'b0, "R9");
      // R3 user write of system byte refused, ALU still applies (R6)
      cyc(5'h1F, 5'h0A, 1'b1, 2'b11, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R3");
      cyc(5'h00, 5'h00, 1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 1'b0, "R10");
      // R4 user may write flags
      cyc(5'h00, 5'h00, 1'b1, 2'b01, 16'hFF13, 1'b0, 1'b0, 1'b0, "R4");
      // R7 full read privileged / open
      cyc(5'h00, 5'h00, 1'b0, 2'b00, 16'h0000, 1'b1, 1'b1, 1'b1, "R7");
      cyc(5'h00, 5'h00, 1'b0, 2'b00, 16'h0000, 1'b1, 1'b1, 1'b0, "R7");
      // R8 flag read in user mode
      cyc(5'h00, 5'h00, 1'b0, 2'b00, 16'h0000, 1'b1, 1'b0, 1'b1, "R8");
      cyc(5'h00, 5'h00, 1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 1'b0, "R8");
      // random phase, periodic reset to regain supervisor mode
      for (int n = 0; n < 3000; n++) begin
         if (n % 250 == 0) do_reset();
         cyc(5'($urandom), 5'($urandom), ($urandom % 3) == 0, 2'($urandom), 16'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom), "R5");
      end
      cyc(5'h00, 5'h00, 1'b0, 2'b00, 16'h0000, 1'b0, 1'b0, 1'b0, "R5");
      done = 1'b1;
   end

   initial begin
      for (int t = 0; t < 150000; t++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule